// File: doc/BRIEF.md
# Divisor-Counting Prime Checker

This block decides whether an 8-bit unsigned operand is prime by brute force. After a start pulse it captures the operand. It then walks a candidate divisor from 1 up to and including the operand. For each candidate it finds the remainder by repeated subtraction, one subtraction per clock, and counts the candidates that leave a remainder of zero. A number is reported prime when exactly two such divisors exist.

The design is split into four parts. A loop-index register also holds the captured operand and raises an end flag on the last candidate. A remainder unit holds the working copy and compares it against the divisor and against zero. A controller sequences the run and keeps the divisor count. A thin top level connects them. The caller pulses `start`, waits for the one-cycle `done` pulse, and then reads `is_prime`. The flag holds its value until the next result.

Top module: `prime_checker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle and clears `done` and `is_prime` to 0. Any run in progress is abandoned, and a start after reset runs normally.
- R2: For an operand N of 2 or more, `is_prime` reads 1 with the result when exactly two values in 1..N divide N with zero remainder, and 0 otherwise.
- R3: Operands 0 and 1 report `is_prime` = 0. Operand 0 runs no divisor iterations.
- R4: Each accepted start produces exactly one `done` pulse, high for a single clock cycle.
- R5: `is_prime` changes only in the cycle in which `done` is high. Between results, including during a later run, it holds the previous result.
- R6: A start pulse seen while a run is in progress is ignored. The operand input is only sampled on the accepting edge, so later changes to it do not affect the result.
- R7: When start is accepted at edge E, `done` is high after edge E + 1 + S, where S is the sum over i = 1..N of (floor(N/i) + 2). For N = 0 this is edge E + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request to begin a run; taken only when idle |
| operand | input | 8 | Unsigned number to test, sampled when start is taken |
| done | output | 1 | One-cycle pulse marking a new result |
| is_prime | output | 1 | 1 when the last operand was prime; held between results |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before the first start. They do not assume that start stays low during a run. The checks on the divisor index and the remainder only apply while a run is iterating, because an operand of 0 skips the loop. The stimulus changes `start` and `operand` only at falling edges, keeps reset low for two edges, and deliberately raises start and changes the operand during a run to exercise the ignore path.

// File: rtl/pc_pkg.sv
// Shared types for the prime checker.
// Assumes: nothing beyond a single clock domain.
package pc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SUB  = 2'd1,
        ST_CHK  = 2'd2,
        ST_FIN  = 2'd3
    } pc_state_t;
endpackage

// File: rtl/pc_index.sv
// Loop-index register: captures the operand, walks the candidate divisor
// from 1 upward, and flags the last candidate (index equal to operand).
// Assumes: adv is only raised while the index is below the operand.
module pc_index #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         adv,
    input  logic         active,
    input  logic [W-1:0] operand,
    output logic [W-1:0] n_q,
    output logic [W-1:0] idx_q,
    output logic         last
);
    localparam logic [W-1:0] ONE = W'(1);

    // Capture the operand and restart or step the candidate divisor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q   <= '0;
            idx_q <= ONE;
        end else if (load) begin
            n_q   <= operand;
            idx_q <= ONE;
        end else if (adv) begin
            idx_q <= idx_q + ONE;
        end
    end

    // End-of-loop flag.
    assign last = (idx_q == n_q);

    // R2: while iterating, the candidate stays within 1..N
    a_r2_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx_q >= ONE && idx_q <= n_q));
endmodule

// File: rtl/pc_remainder.sv
// Iterative remainder unit: holds a working copy of the operand and
// subtracts the candidate divisor once per enabled cycle. It reports
// whether another subtraction fits and whether the copy is zero.
// Assumes: sub is only raised while the divisor is at least 1.
module pc_remainder #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         adv,
    input  logic         sub,
    input  logic [W-1:0] operand,
    input  logic [W-1:0] n_q,
    input  logic [W-1:0] idx_q,
    output logic         ge,
    output logic         zero
);
    logic [W-1:0] work_q;

    // Reload on a new run or candidate; otherwise subtract when asked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            work_q <= '0;
        else if (load)
            work_q <= operand;
        else if (adv)
            work_q <= n_q;
        else if (sub)
            work_q <= work_q - idx_q;
    end

    // Comparators toward the controller.
    assign ge   = (work_q >= idx_q);
    assign zero = (work_q == '0);

    // R2: the working copy never exceeds the captured operand
    a_r2_work_bound: assert property (@(posedge clk) disable iff (!rst_n)
        work_q <= n_q);

    // R2: each subtraction strictly shrinks the working copy
    a_r2_sub_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        sub |=> (work_q < $past(work_q)));
endmodule

// File: rtl/pc_ctrl.sv
// Controller: sequences subtract / check / advance, counts exact
// divisors, and issues the done pulse with the prime verdict.
// Assumes: op_zero reflects the operand input in the start cycle.
module pc_ctrl #(
    parameter int CW = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic op_zero,
    input  logic ge,
    input  logic zero,
    input  logic last,
    output logic load,
    output logic adv,
    output logic sub,
    output logic active,
    output logic done,
    output logic is_prime
);
    import pc_pkg::*;

    localparam logic [CW-1:0] TWO = CW'(2);

    pc_state_t     state_q;
    logic [CW-1:0] count_q;

    // Datapath strobes decoded from the state.
    assign load   = (state_q == ST_IDLE) && start;
    assign sub    = (state_q == ST_SUB) && ge;
    assign adv    = (state_q == ST_CHK) && !last;
    assign active = (state_q == ST_SUB) || (state_q == ST_CHK);

    // State register, divisor counter and result outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            count_q  <= '0;
            done     <= 1'b0;
            is_prime <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    count_q <= '0;
                    state_q <= op_zero ? ST_FIN : ST_SUB;
                end
                ST_SUB: if (!ge) state_q <= ST_CHK;
                ST_CHK: begin
                    if (zero) count_q <= count_q + CW'(1);
                    state_q <= last ? ST_FIN : ST_SUB;
                end
                ST_FIN: begin
                    done     <= 1'b1;
                    is_prime <= (count_q == TWO);
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R4: done never lasts more than one cycle
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: the verdict only moves together with done
    a_r5_prime_held: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(is_prime));
endmodule

// File: rtl/prime_checker.sv
// Top level of the divisor-counting prime checker: connects the index
// register, the remainder unit and the controller.
// Assumes: rst_n is held low for at least one edge before first use.
module prime_checker #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] operand,
    output logic         done,
    output logic         is_prime
);
    localparam int CW = W + 1;

    logic         load, adv, sub, active;
    logic         ge, zero, last;
    logic [W-1:0] n_q, idx_q;
    logic         op_zero;

    // Operand-zero detect used when a start is taken.
    assign op_zero = (operand == '0);

    pc_index #(.W(W)) u_index (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .active(active),
        .operand(operand), .n_q(n_q), .idx_q(idx_q), .last(last)
    );

    pc_remainder #(.W(W)) u_rem (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .sub(sub),
        .operand(operand), .n_q(n_q), .idx_q(idx_q), .ge(ge), .zero(zero)
    );

    pc_ctrl #(.CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op_zero(op_zero),
        .ge(ge), .zero(zero), .last(last), .load(load), .adv(adv),
        .sub(sub), .active(active), .done(done), .is_prime(is_prime)
    );

    // R3: a prime verdict is never given for operand 0 or 1
    a_r3_prime_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
        (done && is_prime) |-> (n_q >= W'(2)));
endmodule

// File: tb/sim_prime_checker.sv
module sim_prime_checker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] operand = '0;
    logic       done, is_prime;
    int         n_checks = 0;
    int         n_fail = 0;
    int         cycles = 0;

    always #4 clk = ~clk;

    prime_checker u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
        .done(done), .is_prime(is_prime)
    );

    // {expected prime, operand}
    localparam logic [8:0] TBL [16] = '{
        {1'b0, 8'd0},   {1'b0, 8'd1},   {1'b1, 8'd2},   {1'b1, 8'd3},
        {1'b0, 8'd4},   {1'b1, 8'd5},   {1'b0, 8'd6},   {1'b0, 8'd9},
        {1'b1, 8'd13},  {1'b0, 8'd25},  {1'b0, 8'd49},  {1'b1, 8'd97},
        {1'b0, 8'd128}, {1'b1, 8'd211}, {1'b1, 8'd251}, {1'b0, 8'd255}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Edges counted from the accepting edge until done is seen (R7 formula).
    function automatic int exp_lat(input int n);
        int s = 0;
        for (int i = 1; i <= n; i++) s += n / i + 2;
        return 2 + s;
    endfunction

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Pulse start at a falling edge and count edges until done.
    task automatic run(input logic [7:0] n, output int lat);
        @(negedge clk);
        operand = n;
        start = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 5000) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
                summary();
            end
        end
    end

    initial begin
        int lat;
        int dones;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(done == 1'b0, "R1 reset done", done, 0);
        check(is_prime == 1'b0, "R1 reset prime", is_prime, 0);
        rst_n = 1'b1;

        // Table walk: R2/R3 verdict, R7 latency, R4 single pulse
        for (int k = 0; k < 16; k++) begin
            logic [7:0] n;
            logic       e;
            n = TBL[k][7:0];
            e = TBL[k][8];
            run(n, lat);
            check(done == 1'b1, "R4 done seen", done, 1);
            check(is_prime == e, (n < 2) ? "R3 small operand" : "R2 verdict", is_prime, e);
            check(lat == exp_lat(n), "R7 latency", lat, exp_lat(n));
            @(negedge clk);
            check(done == 1'b0, "R4 done one cycle", done, 0);
        end

        // R5: the previous verdict (4 -> 0) holds through the next run
        run(8'd4, lat);
        @(negedge clk);
        operand = 8'd97;
        start = 1'b1;
        @(posedge clk);
        lat = 1;
        @(negedge clk);
        start = 1'b0;
        dones = 0;
        // R6: later start and operand change during the run are ignored
        repeat (10) begin @(posedge clk); lat++; @(negedge clk); end
        check(is_prime == 1'b0, "R5 held during run", is_prime, 0);
        operand = 8'd100;
        start = 1'b1;
        @(posedge clk);
        lat++;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 5000) begin @(posedge clk); lat++; @(negedge clk); end
        check(is_prime == 1'b1, "R6 operand captured at start", is_prime, 1);
        check(lat == exp_lat(97), "R6 busy start ignored", lat, exp_lat(97));
        repeat (30) begin
            @(negedge clk);
            if (done) dones++;
        end
        check(dones == 0, "R4 single done per start", dones, 0);
        check(is_prime == 1'b1, "R5 held after done", is_prime, 1);

        // R1: reset mid-run abandons it, then a fresh run works
        @(negedge clk);
        operand = 8'd251;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(done == 1'b0, "R1 mid-run reset done", done, 0);
        check(is_prime == 1'b0, "R1 mid-run reset prime", is_prime, 0);
        rst_n = 1'b1;
        dones = 0;
        repeat (40) begin
            @(negedge clk);
            if (done) dones++;
        end
        check(dones == 0, "R1 abandoned run gives no done", dones, 0);
        run(8'd7, lat);
        check(is_prime == 1'b1, "R1 run after reset", is_prime, 1);
        check(lat == exp_lat(7), "R7 latency after reset", lat, exp_lat(7));

        summary();
    end
endmodule